// File: doc/BRIEF.md
# PCM Time-Slot Serial Interface

This block moves 8-bit PCM samples over a shared serial backplane. Each sample sits in one programmable time-slot of a frame. Everything runs on the bit clock `bclk`. Transmit and receive each have their own frame sync and their own slot counter, so the two frames may be offset from each other by any number of bit clocks.

Frames use delayed-data timing. A frame sync is seen as a rising edge when it is sampled high on a rising `bclk` edge after being sampled low. The first bit of slot 0 starts on the next rising edge. Slots are 8 bits long, sent most significant bit first, and numbered 0 to 63. The count does not wrap: a frame ends after slot 63 or when a new sync edge arrives. Transmit bits change on rising `bclk` edges. Receive bits are sampled on falling edges.

The transmit sample enters through a valid/ready port that holds one sample. `tx_ready` is high while that holding register is empty. A sample is taken on a rising edge with `tx_valid` and `tx_ready` both high. The upstream side may hold `tx_valid` and `tx_data` for as long as `tx_ready` stays low. The receive side has no back-pressure: the line cannot be stalled, so each received byte appears with a one-period `rx_valid` strobe and must be taken then. An external line driver is controlled by `tx_en_n`. `pwr_up` gates all transmit output.

Top module: `pcm_tsi`

## Requirements
- R1: While reset is held and after its release, `tx_oe` is 0, `tx_en_n` is 1, `rx_valid` is 0 and `tx_ready` is 1.
- R2: If `fsx` is first sampled high at rising edge k, bit b of slot n appears on `tx_dx` from rising edge k+1+8n+b for one period. Bit 0 of the slot is the MSB (bit 7) of the transmitted sample.
- R3: `tx_oe` is 1 for exactly the 8 bit periods of slot `tx_slot` and 0 at all other times. `tx_dx` is high-impedance whenever `tx_oe` is 0.
- R4: `tx_en_n` goes low at the rising edge that starts the transmitted slot. It goes high at the falling edge in the middle of the slot's eighth bit, so it is low for 7.5 bit periods.
- R5: If `fsr` is first sampled high at rising edge k, `rx_dr` is sampled at the falling edge in the middle of each bit of slot `rx_slot`, MSB first. At the falling edge of the eighth sample, `rx_data` takes the byte and `rx_valid` is 1 for exactly one period.
- R6: Transmit and receive frames are counted independently and may be offset by any number of bit clocks.
- R7: While `pwr_up` is 0, `tx_oe` is 0 and `tx_en_n` is 1. After `pwr_up` rises, the first frame that transmits is the one started by the second `fsx` rising edge. A frame that does not transmit leaves the held sample in place.
- R8: Each transmitted slot empties the holding register. If the register is empty when the slot starts, the slot sends 8'hFF. While `tx_ready` is 0, `tx_valid` is ignored.
- R9: Slot 63 is transmitted normally. The slot count does not wrap after slot 63: a frame with `tx_slot` = 0 drives nothing after bit 511 until the next `fsx` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_up | input | 1 | 1 = powered up, 0 = powered down |
| fsx | input | 1 | Transmit frame sync |
| fsr | input | 1 | Receive frame sync |
| tx_slot | input | 6 | Assigned transmit slot number |
| rx_slot | input | 6 | Assigned receive slot number |
| tx_data | input | 8 | Transmit sample |
| tx_valid | input | 1 | Transmit sample valid |
| tx_ready | output | 1 | Holding register empty |
| tx_dx | output | 1 | Three-state transmit data |
| tx_oe | output | 1 | Transmit data drive enable |
| tx_en_n | output | 1 | Line driver enable, active low |
| rx_dr | input | 1 | Receive serial data |
| rx_data | output | 8 | Received sample |
| rx_valid | output | 1 | Received sample strobe |

## Verification
Transmit results are due one rising edge after the position they belong to. Bit b of slot n is checked 1 ns after rising edge k+1+8n+b. The release of `tx_en_n` is checked 1 ns after the falling edge of bit 7. The receive strobe is checked 1 ns after the falling edge of the eighth sample, and again one falling edge before and one after. The bench counts edges from the sync edge it drives itself. It sets inputs only at falling edges or 1 ns after rising edges, so every check samples settled outputs away from the edge that changed them.

// File: rtl/pcm_tsi_pkg.sv
`timescale 1ns/1ps
package pcm_tsi_pkg;
  // Power-gate sequencing of the transmit output
  typedef enum logic [1:0] {
    PG_DOWN = 2'd0,
    PG_ARM0 = 2'd1,
    PG_ARM1 = 2'd2,
    PG_LIVE = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pcm_slot_counter.sv
`timescale 1ns/1ps
module pcm_slot_counter #(
  parameter int SLOT_W = 6,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs,
  output logic              fs_rise_o,
  output logic              step_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o
);
  localparam int POS_W = SLOT_W + BIT_W;

  logic             fs_q;
  logic             run_q;
  logic [POS_W-1:0] next_q;
  logic             rise;

  assign rise      = fs & ~fs_q;
  assign fs_rise_o = rise;
  // step_o: a bit of the current frame starts at this rising edge
  assign step_o    = run_q & ~rise;
  assign slot_o    = next_q[POS_W-1:BIT_W];
  assign bit_o     = next_q[BIT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      run_q  <= 1'b0;
      next_q <= '0;
    end else begin
      fs_q <= fs;
      if (rise) begin
        run_q  <= 1'b1;
        next_q <= '0;
      end else if (run_q) begin
        if (next_q == {POS_W{1'b1}}) run_q <= 1'b0;
        next_q <= next_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_power_gate.sv
`timescale 1ns/1ps
module pcm_power_gate
  import pcm_tsi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_up,
  input  logic fs_rise,
  output logic live_o
);
  pg_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_DOWN;
    end else if (!pwr_up) begin
      state_q <= PG_DOWN;
    end else begin
      unique case (state_q)
        PG_DOWN: state_q <= fs_rise ? PG_ARM1 : PG_ARM0;
        PG_ARM0: if (fs_rise) state_q <= PG_ARM1;
        PG_ARM1: if (fs_rise) state_q <= PG_LIVE;
        PG_LIVE: state_q <= PG_LIVE;
        default: state_q <= PG_DOWN;
      endcase
    end
  end

  assign live_o = (state_q == PG_LIVE);
endmodule

// File: rtl/pcm_tx_path.sv
`timescale 1ns/1ps
module pcm_tx_path #(
  parameter int SAMPLE_W = 8,
  parameter int SLOT_W   = 6,
  parameter int BIT_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [BIT_W-1:0]    bitn,
  input  logic [SLOT_W-1:0]   tx_slot,
  input  logic                live,
  input  logic                pwr_up,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                dx_o,
  output logic                oe_o,
  output logic                en_n_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] hold_q;
  logic                full_q;
  logic [SAMPLE_W-1:0] sh_q;
  logic                oe_q;
  logic                last_q;
  logic                cut_q;
  logic                in_slot;
  logic                start;
  logic                accept;

  assign in_slot  = step & (slot == tx_slot) & live;
  assign start    = in_slot & (bitn == '0);
  assign accept   = tx_valid & ~full_q;
  assign tx_ready = ~full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      sh_q   <= '1;
      oe_q   <= 1'b0;
      last_q <= 1'b0;
    end else begin
      oe_q   <= in_slot;
      last_q <= in_slot & (bitn == LAST_BIT);
      if (start) begin
        sh_q   <= full_q ? hold_q : '1;
        full_q <= accept;
        if (accept) hold_q <= tx_data;
      end else begin
        if (in_slot) sh_q <= {sh_q[SAMPLE_W-2:0], 1'b1};
        if (accept) begin
          full_q <= 1'b1;
          hold_q <= tx_data;
        end
      end
    end
  end

  // Releases the line driver half a bit early, mid last bit
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) cut_q <= 1'b0;
    else        cut_q <= oe_q & last_q;
  end

  assign dx_o   = sh_q[SAMPLE_W-1];
  assign oe_o   = oe_q & pwr_up;
  assign en_n_o = ~(oe_o & ~cut_q);
endmodule

// File: rtl/pcm_rx_path.sv
`timescale 1ns/1ps
module pcm_rx_path #(
  parameter int SAMPLE_W = 8,
  parameter int SLOT_W   = 6,
  parameter int BIT_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [BIT_W-1:0]    bitn,
  input  logic [SLOT_W-1:0]   rx_slot,
  input  logic                rx_dr,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SAMPLE_W - 1);

  logic                sel_q;
  logic                lastb_q;
  logic [SAMPLE_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      lastb_q <= 1'b0;
    end else begin
      sel_q   <= step & (slot == rx_slot);
      lastb_q <= (bitn == LAST_BIT);
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (sel_q) begin
        sh_q <= {sh_q[SAMPLE_W-2:0], rx_dr};
        if (lastb_q) begin
          rx_data  <= {sh_q[SAMPLE_W-2:0], rx_dr};
          rx_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_tsi.sv
`timescale 1ns/1ps
module pcm_tsi #(
  parameter int SAMPLE_W = 8,
  parameter int SLOT_W   = 6
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                pwr_up,
  input  logic                fsx,
  input  logic                fsr,
  input  logic [SLOT_W-1:0]   tx_slot,
  input  logic [SLOT_W-1:0]   rx_slot,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                tx_dx,
  output logic                tx_oe,
  output logic                tx_en_n,
  input  logic                rx_dr,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid
);
  localparam int BIT_W = $clog2(SAMPLE_W);

  logic              tx_rise, rx_rise_unused;
  logic              tx_step, rx_step;
  logic [SLOT_W-1:0] tx_pos_slot, rx_pos_slot;
  logic [BIT_W-1:0]  tx_pos_bit, rx_pos_bit;
  logic              live;
  logic              dx_bit;

  pcm_slot_counter #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) tx_cnt_i (
    .clk(bclk), .rst_n(rst_n), .fs(fsx), .fs_rise_o(tx_rise),
    .step_o(tx_step), .slot_o(tx_pos_slot), .bit_o(tx_pos_bit)
  );

  pcm_slot_counter #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) rx_cnt_i (
    .clk(bclk), .rst_n(rst_n), .fs(fsr), .fs_rise_o(rx_rise_unused),
    .step_o(rx_step), .slot_o(rx_pos_slot), .bit_o(rx_pos_bit)
  );

  pcm_power_gate pg_i (
    .clk(bclk), .rst_n(rst_n), .pwr_up(pwr_up), .fs_rise(tx_rise), .live_o(live)
  );

  pcm_tx_path #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .BIT_W(BIT_W)) tx_i (
    .clk(bclk), .rst_n(rst_n), .step(tx_step), .slot(tx_pos_slot),
    .bitn(tx_pos_bit), .tx_slot(tx_slot), .live(live), .pwr_up(pwr_up),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .dx_o(dx_bit), .oe_o(tx_oe), .en_n_o(tx_en_n)
  );

  pcm_rx_path #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .BIT_W(BIT_W)) rx_i (
    .clk(bclk), .rst_n(rst_n), .step(rx_step), .slot(rx_pos_slot),
    .bitn(rx_pos_bit), .rx_slot(rx_slot), .rx_dr(rx_dr),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  assign tx_dx = tx_oe ? dx_bit : 1'bz;
endmodule

// File: rtl/pcm_tsi_checker.sv
`timescale 1ns/1ps
module pcm_tsi_checker (
  input logic bclk,
  input logic rst_n,
  input logic pwr_up,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_oe,
  input logic tx_en_n,
  input logic rx_valid
);
  logic [3:0] oe_run;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n)                   oe_run <= '0;
    else if (!tx_oe)              oe_run <= '0;
    else if (oe_run != 4'hF)      oe_run <= oe_run + 1'b1;
  end

  assert_quiet_when_down_R7: assert property (@(posedge bclk) disable iff (!rst_n)
    !pwr_up |-> (!tx_oe && tx_en_n));

  assert_enable_within_drive_R4: assert property (@(posedge bclk) disable iff (!rst_n)
    !tx_en_n |-> tx_oe);

  assert_strobe_single_R5: assert property (@(negedge bclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_accept_fills_R8: assert property (@(posedge bclk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_slot_length_R3: assert property (@(posedge bclk) disable iff (!rst_n)
    !(tx_oe && oe_run >= 4'd8));
endmodule

bind pcm_tsi pcm_tsi_checker chk_i (
  .bclk(bclk), .rst_n(rst_n), .pwr_up(pwr_up), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_oe(tx_oe), .tx_en_n(tx_en_n), .rx_valid(rx_valid)
);

// File: tb/pcm_tsi_tb_top.sv
`timescale 1ns/1ps
module pcm_tsi_tb_top;
  logic       bclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_up = 1'b0;
  logic       fsx = 1'b0, fsr = 1'b0;
  logic [5:0] tx_slot = '0, rx_slot = '0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       rx_dr = 1'b0;
  wire        tx_ready, tx_dx, tx_oe, tx_en_n, rx_valid;
  wire  [7:0] rx_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 bclk = ~bclk;

  pcm_tsi dut_i (
    .bclk(bclk), .rst_n(rst_n), .pwr_up(pwr_up), .fsx(fsx), .fsr(fsr),
    .tx_slot(tx_slot), .rx_slot(rx_slot), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_dx(tx_dx), .tx_oe(tx_oe), .tx_en_n(tx_en_n),
    .rx_dr(rx_dr), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic push(input logic [7:0] d, input bit expect_ready, input string req);
    @(negedge bclk);
    chk(tx_ready === expect_ready, req, "tx_ready before push", tx_ready, expect_ready);
    tx_valid = 1'b1;
    tx_data  = d;
    @(posedge bclk); #1;
    tx_valid = 1'b0;
    chk(tx_ready === 1'b0, req, "tx_ready after push", tx_ready, 0);
  endtask

  // Drives one transmit frame and checks every bit period up to span
  task automatic tx_frame(input int slot, input logic [7:0] d, input bit on,
                          input int span, input string req);
    @(negedge bclk);
    fsx = 1'b1;
    tx_slot = 6'(slot);
    @(posedge bclk);
    @(negedge bclk);
    fsx = 1'b0;
    for (int e = 1; e <= span; e++) begin
      int  idx;
      int  b;
      bit  ins;
      idx = e - 1;
      ins = on && (idx >= 8*slot) && (idx < 8*slot + 8);
      b   = idx - 8*slot;
      @(posedge bclk); #1;
      chk(tx_oe === ins, req, "tx_oe", tx_oe, ins);
      chk(tx_en_n === !ins, req, "tx_en_n after rise", tx_en_n, !ins);
      if (ins) chk(tx_dx === d[7-b], req, "tx_dx bit", tx_dx, d[7-b]);
      @(negedge bclk); #1;
      chk(tx_en_n === !(ins && b < 7), req, "tx_en_n after fall", tx_en_n, !(ins && b < 7));
    end
  endtask

  task automatic rx_frame(input int slot, input logic [7:0] d, input string req);
    @(negedge bclk);
    fsr = 1'b1;
    rx_slot = 6'(slot);
    @(posedge bclk);
    @(negedge bclk);
    fsr = 1'b0;
    for (int e = 1; e <= 8*slot + 10; e++) begin
      int idx;
      bit ins;
      bit last;
      idx  = e - 1;
      ins  = (idx >= 8*slot) && (idx < 8*slot + 8);
      last = (idx == 8*slot + 7);
      @(posedge bclk); #1;
      rx_dr = ins ? d[7 - (idx - 8*slot)] : idx[0];
      @(negedge bclk); #1;
      chk(rx_valid === last, req, "rx_valid", rx_valid, last);
      if (last) chk(rx_data === d, req, "rx_data", rx_data, d);
    end
  endtask

  task automatic test_reset;
    #1;
    chk(tx_oe === 1'b0 && tx_en_n === 1'b1, "R1", "outputs in reset", {tx_oe, tx_en_n}, 2'b01);
    repeat (3) @(posedge bclk);
    @(negedge bclk) rst_n = 1'b1;
    repeat (2) @(posedge bclk); #1;
    chk(tx_oe === 1'b0, "R1", "tx_oe after reset", tx_oe, 0);
    chk(tx_en_n === 1'b1, "R1", "tx_en_n after reset", tx_en_n, 1);
    chk(rx_valid === 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
    chk(tx_ready === 1'b1, "R1", "tx_ready after reset", tx_ready, 1);
  endtask

  task automatic test_power;
    tx_frame(2, 8'h00, 0, 30, "R7");
    @(negedge bclk) pwr_up = 1'b1;
    push(8'hA5, 1, "R7");
    tx_frame(2, 8'hA5, 0, 30, "R7");
    chk(tx_ready === 1'b0, "R7", "sample kept while not live", tx_ready, 0);
    tx_frame(2, 8'hA5, 1, 30, "R7");
    @(negedge bclk) pwr_up = 1'b0;
    push(8'h11, 1, "R7");
    tx_frame(1, 8'h11, 0, 20, "R7");
    @(negedge bclk) pwr_up = 1'b1;
    tx_frame(1, 8'h11, 0, 20, "R7");
    tx_frame(1, 8'h11, 1, 20, "R7");
  endtask

  task automatic test_tx_patterns;
    push(8'h3C, 1, "R2");
    tx_frame(0, 8'h3C, 1, 12, "R2");
    push(8'h81, 1, "R3");
    tx_frame(5, 8'h81, 1, 50, "R3");
    push(8'h6B, 1, "R4");
    tx_frame(9, 8'h6B, 1, 82, "R4");
  endtask

  task automatic test_holding;
    tx_frame(1, 8'hFF, 1, 20, "R8");
    push(8'h55, 1, "R8");
    push(8'h00, 0, "R8");
    tx_frame(3, 8'h55, 1, 34, "R8");
    chk(tx_ready === 1'b1, "R8", "emptied by slot", tx_ready, 1);
  endtask

  task automatic test_rx;
    rx_frame(0, 8'hC3, "R5");
    rx_frame(7, 8'h5A, "R5");
  endtask

  task automatic test_skew;
    push(8'h96, 1, "R6");
    fork
      tx_frame(3, 8'h96, 1, 34, "R6");
      begin
        repeat (13) @(posedge bclk);
        rx_frame(4, 8'h69, "R6");
      end
    join
  endtask

  task automatic test_last_slot;
    push(8'hE7, 1, "R9");
    tx_frame(63, 8'hE7, 1, 8*63 + 10, "R9");
    push(8'h4D, 1, "R9");
    tx_frame(0, 8'h4D, 1, 530, "R9");
  endtask

  initial begin
    test_reset();
    test_power();
    test_tx_patterns();
    test_holding();
    test_rx();
    test_skew();
    test_last_slot();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule